// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Checking

This block holds a small set of recently used page translations and answers address lookups in the same cycle they are presented. A lookup carries a virtual page number, an access kind (read, write or execute) and a process tag. Every slot is compared in parallel. The result is one of four codes: no lookup, hit with the physical page number, miss, or protection fault when the matching slot's rights forbid the requested access.

A page table walker fills slots through the insert port after a miss. The slot to overwrite is chosen from the per-slot use bits. These bits are set by every permitted access and are wiped by a periodic clear strobe from outside, which gives a cheap approximation of least-recently-used order. On a context switch the whole array can be emptied in a single cycle. Slots can also stay resident, because a hit requires the stored process tag to match the lookup tag. A write hit marks the slot dirty, and the dirty bit is reported with each hit so that the walker can tell when the page table still has to be updated.

Top module: `tlb_cam`

## Requirements
- R1: The array is fully associative with `ENTRIES` slots (default 32). When `lk_valid` is 1 and a valid slot holds a matching VPN (and process tag, see R9), `res_kind` is 1 (hit) and `res_ppn` carries that slot's PPN in the same cycle.
- R2: When `lk_valid` is 0, `res_kind` is 0 (idle). When `lk_valid` is 1 and no valid slot matches, `res_kind` is 2 (miss). In both cases `res_ppn` and `res_dirty` are 0.
- R3: Rights bit 0 allows read, bit 1 allows write and bit 2 allows execute. `lk_acc` is 0 for read, 1 for write and 2 for execute. A matching slot without the needed right gives `res_kind` 3 (fault) with `res_ppn` 0, and it leaves that slot's dirty and use bits unchanged.
- R4: A permitted hit sets the slot's use bit at the next clock edge. A `ref_clear` pulse clears every use bit at the edge. A permitted access in the same cycle as `ref_clear` still leaves its own slot's bit set.
- R5: `flush` empties every slot at the next edge. If `flush` and `ins_valid` are both high in one cycle, the flush wins and nothing is written.
- R6: An insert writes the lowest-index empty slot. When every slot is full, it writes the lowest-index slot whose use bit is clear. When every use bit is set, it writes slot 0.
- R7: An insert stores the VPN, PPN, process tag, rights and dirty values at the clock edge. The slot becomes valid with its use bit set and can be hit from the next cycle.
- R8: A permitted write hit sets the slot's dirty bit at the edge. On a hit, `res_dirty` reports the slot's stored dirty bit.
- R9: With `USE_PID` = 1 (default), a slot matches only when its stored process tag equals `lk_pid`. A slot inserted under one tag misses for a lookup under another tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, empties the array |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_pid | input | PID_W | Process tag of the lookup |
| res_kind | output | 2 | 0 idle, 1 hit, 2 miss, 3 protection fault |
| res_ppn | output | PPN_W | Physical page number on a hit, else 0 |
| res_dirty | output | 1 | Stored dirty bit of the hit slot, else 0 |
| ins_valid | input | 1 | Write a new translation this cycle |
| ins_vpn | input | VPN_W | VPN of the new translation |
| ins_ppn | input | PPN_W | PPN of the new translation |
| ins_pid | input | PID_W | Process tag of the new translation |
| ins_rights | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| ins_dirty | input | 1 | Dirty state taken from the page table |
| flush | input | 1 | Empty all slots at the next edge |
| ref_clear | input | 1 | Clear all use bits at the next edge |

## Verification
Lookups are run against a read-only slot with all three access kinds. This shows a permitted hit apart from a fault, and it shows that a fault leaves the dirty bit alone. The same VPN is looked up under a second process tag to tell a tag mismatch from a VPN mismatch. The array is then filled completely, and the overflow inserts are aimed after different use-bit patterns: all bits set, then all cleared except those touched afterwards, including one touched in the clear cycle itself. Which VPN disappears after each overflow tells apart the three victim rules and the priority of an access over the clear strobe. A flush coinciding with an insert shows that the flush takes priority.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [1:0] RES_IDLE  = 2'd0;
  localparam logic [1:0] RES_HIT   = 2'd1;
  localparam logic [1:0] RES_MISS  = 2'd2;
  localparam logic [1:0] RES_FAULT = 2'd3;

  // rights: bit0 read, bit1 write, bit2 execute
  function automatic logic rights_allow(input logic [2:0] rights, input logic [1:0] acc);
    case (acc)
      ACC_READ:  return rights[0];
      ACC_WRITE: return rights[1];
      ACC_EXEC:  return rights[2];
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot #(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PID_W   = 8,
  parameter bit USE_PID = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             ref_clear,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [2:0]       wr_rights,
  input  logic             wr_dirty,
  input  logic             touch,
  input  logic             touch_wr,
  input  logic [VPN_W-1:0] q_vpn,
  input  logic [PID_W-1:0] q_pid,
  output logic             match,
  output logic             valid_o,
  output logic             ref_o,
  output logic [2:0]       rights_o,
  output logic             dirty_o,
  output logic [PPN_W-1:0] ppn_o
);
  logic             valid_q, ref_q, dirty_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] ppn_q;
  logic [2:0]       rights_q;
  logic             pid_eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      ref_q    <= 1'b0;
      dirty_q  <= 1'b0;
      vpn_q    <= '0;
      ppn_q    <= '0;
      rights_q <= '0;
    end else if (flush) begin
      valid_q <= 1'b0;
      ref_q   <= 1'b0;
    end else if (wr_en) begin
      valid_q  <= 1'b1;
      ref_q    <= 1'b1;
      dirty_q  <= wr_dirty;
      vpn_q    <= wr_vpn;
      ppn_q    <= wr_ppn;
      rights_q <= wr_rights;
    end else begin
      if (ref_clear) ref_q <= 1'b0;
      if (touch) begin
        ref_q <= 1'b1;
        if (touch_wr) dirty_q <= 1'b1;
      end
    end
  end

  generate
    if (USE_PID) begin : g_pid
      logic [PID_W-1:0] pid_q;
      always_ff @(posedge clk) begin
        if (rst)                 pid_q <= '0;
        else if (wr_en && !flush) pid_q <= wr_pid;
      end
      assign pid_eq = (pid_q == q_pid);
    end else begin : g_nopid
      assign pid_eq = 1'b1;
    end
  endgenerate

  assign match    = valid_q && (vpn_q == q_vpn) && pid_eq;
  assign valid_o  = valid_q;
  assign ref_o    = ref_q;
  assign rights_o = rights_q;
  assign dirty_o  = dirty_q;
  assign ppn_o    = ppn_q;

  // R4: a permitted access leaves the use bit set, even beside a clear strobe
  p_touch_sets_ref_r4: assert property (@(posedge clk) disable iff (rst)
    (touch && !flush && !wr_en) |=> ref_q);

  // R8: a permitted write access marks the slot dirty
  p_write_dirty_r8: assert property (@(posedge clk) disable iff (rst)
    (touch && touch_wr && !flush && !wr_en) |=> dirty_q);

  // R7: an insert makes the slot live and recently used
  p_insert_live_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> (valid_q && ref_q && vpn_q == $past(wr_vpn)));
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] ref_vec,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] free_idx, cold_idx;
  logic             any_free, any_cold;

  always_comb begin
    free_idx = '0;
    cold_idx = '0;
    any_free = 1'b0;
    any_cold = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
      if (!ref_vec[i]) begin
        cold_idx = IDX_W'(i);
        any_cold = 1'b1;
      end
    end
    if (any_free)      victim = free_idx;
    else if (any_cold) victim = cold_idx;
    else               victim = '0;
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PID_W   = 8,
  parameter bit USE_PID = 1'b1,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [1:0]       lk_acc,
  input  logic [PID_W-1:0] lk_pid,
  output logic [1:0]       res_kind,
  output logic [PPN_W-1:0] res_ppn,
  output logic             res_dirty,
  input  logic             ins_valid,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [PID_W-1:0] ins_pid,
  input  logic [2:0]       ins_rights,
  input  logic             ins_dirty,
  input  logic             flush,
  input  logic             ref_clear
);
  logic [ENTRIES-1:0] match_vec, valid_vec, ref_vec, dirty_vec, touch_vec, wr_vec;
  logic [PPN_W-1:0]   ppn_arr    [ENTRIES];
  logic [2:0]         rights_arr [ENTRIES];
  logic [IDX_W-1:0]   sel, victim;
  logic               hit, allow;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      assign wr_vec[g]    = ins_valid && (victim == IDX_W'(g));
      assign touch_vec[g] = lk_valid && hit && allow && (sel == IDX_W'(g));
      tlb_slot #(
        .VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W), .USE_PID(USE_PID)
      ) u_slot (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .ref_clear (ref_clear),
        .wr_en     (wr_vec[g]),
        .wr_vpn    (ins_vpn),
        .wr_ppn    (ins_ppn),
        .wr_pid    (ins_pid),
        .wr_rights (ins_rights),
        .wr_dirty  (ins_dirty),
        .touch     (touch_vec[g]),
        .touch_wr  (lk_acc == ACC_WRITE),
        .q_vpn     (lk_vpn),
        .q_pid     (lk_pid),
        .match     (match_vec[g]),
        .valid_o   (valid_vec[g]),
        .ref_o     (ref_vec[g]),
        .rights_o  (rights_arr[g]),
        .dirty_o   (dirty_vec[g]),
        .ppn_o     (ppn_arr[g])
      );
    end
  endgenerate

  tlb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .valid_vec (valid_vec),
    .ref_vec   (ref_vec),
    .victim    (victim)
  );

  // lowest matching slot wins if a tag was ever loaded twice
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match_vec[i]) sel = IDX_W'(i);
  end

  assign hit   = |match_vec;
  assign allow = rights_allow(rights_arr[sel], lk_acc);

  always_comb begin
    res_kind  = RES_IDLE;
    res_ppn   = '0;
    res_dirty = 1'b0;
    if (lk_valid) begin
      if (!hit) begin
        res_kind = RES_MISS;
      end else if (allow) begin
        res_kind  = RES_HIT;
        res_ppn   = ppn_arr[sel];
        res_dirty = dirty_vec[sel];
      end else begin
        res_kind = RES_FAULT;
      end
    end
  end

  // R5: a flush leaves no slot live, whatever else happened that cycle
  p_flush_empty_r5: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_vec == '0));

  // R3: a refused access leaves every dirty bit as it was
  p_fault_keeps_dirty_r3: assert property (@(posedge clk) disable iff (rst)
    (res_kind == RES_FAULT && !ins_valid && !flush) |=> $stable(dirty_vec));

  // R6: while a free slot exists the insert lands in a free slot
  p_victim_free_r6: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !(&valid_vec)) |-> !valid_vec[victim]);

  // R1: a hit reports the live slot's page number
  p_hit_live_r1: assert property (@(posedge clk) disable iff (rst)
    (res_kind == RES_HIT) |-> (valid_vec[sel] && res_ppn == ppn_arr[sel]));
endmodule

// File: tb/tlb_cam_test.sv
`timescale 1ns/1ps
module tlb_cam_test;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int PID_W = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             lk_valid = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [1:0]       lk_acc = '0;
  logic [PID_W-1:0] lk_pid = '0;
  logic [1:0]       res_kind;
  logic [PPN_W-1:0] res_ppn;
  logic             res_dirty;
  logic             ins_valid = 1'b0;
  logic [VPN_W-1:0] ins_vpn = '0;
  logic [PPN_W-1:0] ins_ppn = '0;
  logic [PID_W-1:0] ins_pid = '0;
  logic [2:0]       ins_rights = '0;
  logic             ins_dirty = 1'b0;
  logic             flush = 1'b0;
  logic             ref_clear = 1'b0;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  tlb_cam uut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_acc(lk_acc), .lk_pid(lk_pid),
    .res_kind(res_kind), .res_ppn(res_ppn), .res_dirty(res_dirty),
    .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_pid(ins_pid),
    .ins_rights(ins_rights), .ins_dirty(ins_dirty),
    .flush(flush), .ref_clear(ref_clear)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // drive a lookup at the falling edge, sample before the rising edge;
  // the lookup stays presented across that rising edge
  task automatic look(input string tag, input logic [VPN_W-1:0] vpn, input logic [1:0] acc,
                      input logic [PID_W-1:0] pid, input logic [1:0] ekind,
                      input logic [PPN_W-1:0] eppn);
    @(negedge clk);
    ins_valid = 1'b0; flush = 1'b0; ref_clear = 1'b0;
    lk_valid = 1'b1; lk_vpn = vpn; lk_acc = acc; lk_pid = pid;
    #2;
    check({tag, " kind"}, 32'(res_kind), 32'(ekind));
    check({tag, " ppn"},  32'(res_ppn),  32'(eppn));
  endtask

  task automatic insert(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                        input logic [PID_W-1:0] pid, input logic [2:0] rights,
                        input logic dirty);
    @(negedge clk);
    lk_valid = 1'b0; flush = 1'b0; ref_clear = 1'b0;
    ins_valid = 1'b1; ins_vpn = vpn; ins_ppn = ppn; ins_pid = pid;
    ins_rights = rights; ins_dirty = dirty;
  endtask

  task automatic quiet();
    @(negedge clk);
    lk_valid = 1'b0; ins_valid = 1'b0; flush = 1'b0; ref_clear = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    lk_valid = 1'b0; ins_valid = 1'b0; ref_clear = 1'b0; flush = 1'b1;
    quiet();
  endtask

  task automatic t_reset();
    look("R2 reset lookup", 20'h00100, 2'd0, 8'd1, 2'd2, '0);
    quiet();
    #2;
    check("R2 idle kind", 32'(res_kind), 32'd0);
  endtask

  task automatic t_rights();
    insert(20'h00100, 20'h00055, 8'd1, 3'b001, 1'b0);
    quiet();
    look("R1 R7 read hit", 20'h00100, 2'd0, 8'd1, 2'd1, 20'h00055);
    check("R8 clean dirty", 32'(res_dirty), 32'd0);
    look("R3 write fault", 20'h00100, 2'd1, 8'd1, 2'd3, '0);
    look("R3 exec fault", 20'h00100, 2'd2, 8'd1, 2'd3, '0);
    look("R3 no dirty after fault", 20'h00100, 2'd0, 8'd1, 2'd1, 20'h00055);
    check("R3 dirty unchanged", 32'(res_dirty), 32'd0);
    look("R9 other pid miss", 20'h00100, 2'd0, 8'd2, 2'd2, '0);
    look("R2 other vpn miss", 20'h00101, 2'd0, 8'd1, 2'd2, '0);
    check("R2 miss dirty", 32'(res_dirty), 32'd0);
  endtask

  task automatic t_dirty();
    insert(20'h00200, 20'h00077, 8'd1, 3'b011, 1'b0);
    quiet();
    look("R8 write hit", 20'h00200, 2'd1, 8'd1, 2'd1, 20'h00077);
    check("R8 dirty before edge", 32'(res_dirty), 32'd0);
    look("R8 read after write", 20'h00200, 2'd0, 8'd1, 2'd1, 20'h00077);
    check("R8 dirty set", 32'(res_dirty), 32'd1);
    insert(20'h00300, 20'h00099, 8'd1, 3'b100, 1'b1);
    quiet();
    look("R7 exec hit", 20'h00300, 2'd2, 8'd1, 2'd1, 20'h00099);
    check("R7 dirty loaded", 32'(res_dirty), 32'd1);
  endtask

  task automatic t_flush();
    @(negedge clk);
    lk_valid = 1'b0; ref_clear = 1'b0;
    flush = 1'b1; ins_valid = 1'b1; ins_vpn = 20'h05000; ins_ppn = 20'h00011;
    ins_pid = 8'd1; ins_rights = 3'b111; ins_dirty = 1'b0;
    quiet();
    look("R5 old entry gone", 20'h00100, 2'd0, 8'd1, 2'd2, '0);
    look("R5 insert lost to flush", 20'h05000, 2'd0, 8'd1, 2'd2, '0);
  endtask

  task automatic t_victims();
    do_flush();
    for (int i = 0; i < 32; i++)
      insert(20'h01000 + 20'(i), 20'h02000 + 20'(i), 8'd1, 3'b111, 1'b0);
    quiet();
    // every fill must have gone to its own free slot
    for (int i = 0; i < 32; i++)
      look("R6 free slot fill", 20'h01000 + 20'(i), 2'd0, 8'd1, 2'd1, 20'h02000 + 20'(i));
    insert(20'h03000, 20'h0aaaa, 8'd1, 3'b111, 1'b0);
    quiet();
    look("R6 all used evicts slot0", 20'h01000, 2'd0, 8'd1, 2'd2, '0);
    look("R6 new entry present", 20'h03000, 2'd0, 8'd1, 2'd1, 20'h0aaaa);
    look("R6 slot1 kept", 20'h01001, 2'd0, 8'd1, 2'd1, 20'h02001);
    // clear strobe with a simultaneous access to the fourth fill
    @(negedge clk);
    ins_valid = 1'b0; flush = 1'b0; ref_clear = 1'b1;
    lk_valid = 1'b1; lk_vpn = 20'h01003; lk_acc = 2'd0; lk_pid = 8'd1;
    quiet();
    look("R4 touch slot0", 20'h03000, 2'd0, 8'd1, 2'd1, 20'h0aaaa);
    for (int i = 1; i < 32; i++)
      if (i != 3 && i != 5)
        look("R4 touch", 20'h01000 + 20'(i), 2'd0, 8'd1, 2'd1, 20'h02000 + 20'(i));
    insert(20'h04000, 20'h0bbbb, 8'd1, 3'b111, 1'b0);
    quiet();
    look("R6 cold slot evicted", 20'h01005, 2'd0, 8'd1, 2'd2, '0);
    look("R4 access beats clear", 20'h01003, 2'd0, 8'd1, 2'd1, 20'h02003);
    look("R6 cold slot refilled", 20'h04000, 2'd0, 8'd1, 2'd1, 20'h0bbbb);
    look("R6 neighbour kept", 20'h01006, 2'd0, 8'd1, 2'd1, 20'h02006);
    quiet();
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rights();
    t_dirty();
    t_flush();
    t_victims();
    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule